// File: doc/BRIEF.md
# Instruction Fetch and Class Decode Front End

This block is the front end of a 32-bit RISC pipeline. It keeps one instruction word prefetched ahead of the word being issued. On each issue cycle the prefetched word moves to the issue slot and the next word is fetched from the program counter, which then moves up by four. When the execution side writes the program counter, the prefetched word is thrown away. The block spends one cycle refilling the prefetch slot from the new address and only then issues again.

Before an issued word is classified, its 4-bit condition field (bits 31:28) is tested against the current N, Z, C and V flags. A word whose condition fails is dropped silently. A word whose condition passes is run through a fixed, priority-ordered list of mask/match tests. The result is presented for one cycle as a one-hot class vector, together with the word and its address. A word that passes its condition but matches no pattern raises a sticky halt. After a halt, nothing is fetched or issued again until reset.

The execution units sit downstream. They consume the class strobe and report taken branches and other program-counter changes through the write port.

Top module: `insn_front`

## Requirements
- R1: While reset is asserted, `issue_valid` is 0, `halted` is 0 and `imem_addr` equals `RESET_PC`. After reset is released, the first edge refills the prefetch slot without issuing. The second edge presents the word at `RESET_PC` with `issue_valid` high.
- R2: Each issued instruction raises `issue_valid` for exactly one cycle. On back-to-back issue cycles, `issue_addr` increases by 4.
- R3: Class bits are assigned as follows, with `w` the 32-bit word. Bit 0: multiply, `w & 0x0fc000f0 == 0x00000090`. Bit 1: status read, `w & 0x0fb000f0 == 0x01000000`. Bit 2: status write, same mask, value `0x01200000`. Bit 3: ALU with shift by constant, `w & 0x0e000010 == 0`. Bit 4: ALU with shift by register, `w & 0x0e000090 == 0x10`. Bit 5: ALU with immediate, `w & 0x0e000000 == 0x02000000`. Bit 6: load/store with immediate offset, same mask, `0x04000000`. Bit 7: load/store with register offset, `w & 0x0e000010 == 0x06000000`. Bit 8: block transfer, `w & 0x0e000000 == 0x08000000`. Bit 9: branch, same mask, `0x0a000000`.
- R4: A word that matches more than one pattern of R3 is reported only in the lowest-numbered matching bit. Bit number is priority.
- R5: The condition code in bits 31:28 is evaluated against `flags_nzcv`, where bit 3 is N, bit 2 is Z, bit 1 is C and bit 0 is V. The codes are: 0 Z, 1 !Z, 2 C, 3 !C, 4 N, 5 !N, 6 V, 7 !V, 8 C&!Z, 9 !C|Z, A N==V, B N!=V, C !Z&(N==V), D Z|(N!=V), E always.
- R6: With `COND_NV_NEVER` = 1, code F never passes. A word whose condition fails produces no `issue_valid` and never sets `halted`, even if its body matches no pattern.
- R7: A word that passes its condition and matches no pattern produces no `issue_valid` and sets `halted`. `halted` stays set until reset. While it is set, nothing issues, `imem_addr` holds its value and program-counter writes are ignored.
- R8: A program-counter write produces no issue at that edge or at the following refill edge. The next word issued is the one at the written address, and the word that was prefetched before the write never issues.
- R9: `issue_class` is all zeros whenever `issue_valid` is 0 and has exactly one bit set whenever `issue_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_addr | output | ADDR_W | Instruction memory read address (current program counter) |
| imem_rdata | input | 32 | Word at `imem_addr`, combinational read |
| pc_wr_en | input | 1 | Program counter write strobe |
| pc_wr_data | input | ADDR_W | New program counter value |
| flags_nzcv | input | 4 | Condition flags N, Z, C, V (bit 3 down to bit 0) |
| issue_valid | output | 1 | One-cycle strobe for an issued instruction |
| issue_class | output | 10 | One-hot instruction class |
| issue_addr | output | ADDR_W | Address of the issued word |
| issue_word | output | 32 | The issued word |
| halted | output | 1 | Sticky unknown-encoding halt |

## Verification
The bench builds the block with `ADDR_W` = 12 and `RESET_PC` = 0x040. The non-zero reset vector cannot be confused with a cleared program counter, so R1's first-issue address is checked for real. The narrow address lets a small memory model hold every program and branch target. `COND_NV_NEVER` is left at 1, so a code-F word with an unknown body exercises the rule that a failed condition cannot halt. Condition sweeps across four flag patterns cover every row of the condition table. A program-counter write issued mid-stream lets the bench measure the two-cycle issue gap directly.

// File: rtl/fe_pkg.sv
package fe_pkg;

   localparam int NCLASS = 10;

   localparam int CLS_MUL    = 0;
   localparam int CLS_SR_RD  = 1;
   localparam int CLS_SR_WR  = 2;
   localparam int CLS_ALU_KS = 3;
   localparam int CLS_ALU_RS = 4;
   localparam int CLS_ALU_IM = 5;
   localparam int CLS_LS_IM  = 6;
   localparam int CLS_LS_RG  = 7;
   localparam int CLS_BLOCK  = 8;
   localparam int CLS_BRANCH = 9;

   function automatic logic [31:0] cls_mask(input int idx);
      case (idx)
         CLS_MUL:                 cls_mask = 32'h0fc0_00f0;
         CLS_SR_RD, CLS_SR_WR:    cls_mask = 32'h0fb0_00f0;
         CLS_ALU_KS, CLS_LS_RG:   cls_mask = 32'h0e00_0010;
         CLS_ALU_RS:              cls_mask = 32'h0e00_0090;
         default:                 cls_mask = 32'h0e00_0000;
      endcase
   endfunction

   function automatic logic [31:0] cls_match(input int idx);
      case (idx)
         CLS_MUL:    cls_match = 32'h0000_0090;
         CLS_SR_RD:  cls_match = 32'h0100_0000;
         CLS_SR_WR:  cls_match = 32'h0120_0000;
         CLS_ALU_KS: cls_match = 32'h0000_0000;
         CLS_ALU_RS: cls_match = 32'h0000_0010;
         CLS_ALU_IM: cls_match = 32'h0200_0000;
         CLS_LS_IM:  cls_match = 32'h0400_0000;
         CLS_LS_RG:  cls_match = 32'h0600_0000;
         CLS_BLOCK:  cls_match = 32'h0800_0000;
         default:    cls_match = 32'h0a00_0000;
      endcase
   endfunction

endpackage

// File: rtl/fe_cond_eval.sv
module fe_cond_eval #(
   parameter bit NV_NEVER = 1'b1
) (
   input  logic [3:0] code,
   input  logic [3:0] flags_nzcv,
   output logic       pass
);
   logic fn, fz, fc, fv, nv_pass;

   assign fn = flags_nzcv[3];
   assign fz = flags_nzcv[2];
   assign fc = flags_nzcv[1];
   assign fv = flags_nzcv[0];

   generate
      if (NV_NEVER) begin : g_nv_never
         assign nv_pass = 1'b0;
      end else begin : g_nv_always
         assign nv_pass = 1'b1;
      end
   endgenerate

   always_comb begin
      case (code)
         4'h0: pass = fz;
         4'h1: pass = !fz;
         4'h2: pass = fc;
         4'h3: pass = !fc;
         4'h4: pass = fn;
         4'h5: pass = !fn;
         4'h6: pass = fv;
         4'h7: pass = !fv;
         4'h8: pass = fc && !fz;
         4'h9: pass = !fc || fz;
         4'hA: pass = (fn == fv);
         4'hB: pass = (fn != fv);
         4'hC: pass = !fz && (fn == fv);
         4'hD: pass = fz || (fn != fv);
         4'hE: pass = 1'b1;
         default: pass = nv_pass;
      endcase
   end
endmodule

// File: rtl/fe_class_decode.sv
module fe_class_decode
   import fe_pkg::*;
(
   input  logic [31:0]       word,
   output logic [NCLASS-1:0] onehot,
   output logic              known
);
   logic [NCLASS-1:0] hit;
   logic [NCLASS:0]   seen;

   assign seen[0] = 1'b0;

   generate
      for (genvar i = 0; i < NCLASS; i++) begin : g_pat
         assign hit[i]     = (word & cls_mask(i)) == cls_match(i);
         assign onehot[i]  = hit[i] && !seen[i];
         assign seen[i+1]  = seen[i] || hit[i];
      end
   endgenerate

   assign known = seen[NCLASS];
endmodule

// File: rtl/fe_fetch_ctl.sv
module fe_fetch_ctl #(
   parameter int          ADDR_W   = 32,
   parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              halt,
   input  logic              pc_wr_en,
   input  logic [ADDR_W-1:0] pc_wr_data,
   input  logic [31:0]       imem_rdata,
   output logic [ADDR_W-1:0] pc,
   output logic [31:0]       pf_word,
   output logic [ADDR_W-1:0] pf_addr,
   output logic              issue_go
);
   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

   logic reload;

   assign issue_go = !halt && !pc_wr_en && !reload;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc      <= RESET_PC;
         reload  <= 1'b1;
         pf_word <= '0;
         pf_addr <= '0;
      end else if (!halt) begin
         if (pc_wr_en) begin
            pc     <= pc_wr_data;
            reload <= 1'b1;
         end else begin
            pf_word <= imem_rdata;
            pf_addr <= pc;
            pc      <= pc + STEP;
            reload  <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/fe_issue_stage.sv
module fe_issue_stage
   import fe_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue_go,
   input  logic              cond_ok,
   input  logic              known,
   input  logic [NCLASS-1:0] class_oh,
   input  logic [31:0]       pf_word,
   input  logic [ADDR_W-1:0] pf_addr,
   output logic              issue_valid,
   output logic [NCLASS-1:0] issue_class,
   output logic [ADDR_W-1:0] issue_addr,
   output logic [31:0]       issue_word,
   output logic              halted
);
   logic take;

   assign take = issue_go && cond_ok && known;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         issue_valid <= 1'b0;
         issue_class <= '0;
         issue_addr  <= '0;
         issue_word  <= '0;
         halted      <= 1'b0;
      end else begin
         issue_valid <= take;
         issue_class <= take ? class_oh : '0;
         if (issue_go) begin
            issue_addr <= pf_addr;
            issue_word <= pf_word;
            if (cond_ok && !known) halted <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/insn_front.sv
module insn_front
   import fe_pkg::*;
#(
   parameter int          ADDR_W        = 32,
   parameter logic [ADDR_W-1:0] RESET_PC = '0,
   parameter bit          COND_NV_NEVER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [ADDR_W-1:0] imem_addr,
   input  logic [31:0]       imem_rdata,
   input  logic              pc_wr_en,
   input  logic [ADDR_W-1:0] pc_wr_data,
   input  logic [3:0]        flags_nzcv,
   output logic              issue_valid,
   output logic [NCLASS-1:0] issue_class,
   output logic [ADDR_W-1:0] issue_addr,
   output logic [31:0]       issue_word,
   output logic              halted
);
   generate
      if (ADDR_W < 3 || ADDR_W > 32) begin : g_bad_width
         $error("insn_front: ADDR_W must lie in 3..32");
      end
      if (RESET_PC[1:0] != 2'b00) begin : g_bad_vector
         $error("insn_front: RESET_PC must be word aligned");
      end
   endgenerate

   logic [31:0]       pf_word;
   logic [ADDR_W-1:0] pf_addr;
   logic              issue_go;
   logic              cond_ok;
   logic              known;
   logic [NCLASS-1:0] class_oh;

   fe_fetch_ctl #(.ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) u_fetch (
      .clk        (clk),
      .rst_n      (rst_n),
      .halt       (halted),
      .pc_wr_en   (pc_wr_en),
      .pc_wr_data (pc_wr_data),
      .imem_rdata (imem_rdata),
      .pc         (imem_addr),
      .pf_word    (pf_word),
      .pf_addr    (pf_addr),
      .issue_go   (issue_go)
   );

   fe_cond_eval #(.NV_NEVER(COND_NV_NEVER)) u_cond (
      .code       (pf_word[31:28]),
      .flags_nzcv (flags_nzcv),
      .pass       (cond_ok)
   );

   fe_class_decode u_dec (
      .word   (pf_word),
      .onehot (class_oh),
      .known  (known)
   );

   fe_issue_stage #(.ADDR_W(ADDR_W)) u_issue (
      .clk         (clk),
      .rst_n       (rst_n),
      .issue_go    (issue_go),
      .cond_ok     (cond_ok),
      .known       (known),
      .class_oh    (class_oh),
      .pf_word     (pf_word),
      .pf_addr     (pf_addr),
      .issue_valid (issue_valid),
      .issue_class (issue_class),
      .issue_addr  (issue_addr),
      .issue_word  (issue_word),
      .halted      (halted)
   );
endmodule

// File: rtl/insn_front_chk.sv
module insn_front_chk
   import fe_pkg::*;
#(
   parameter int ADDR_W        = 32,
   parameter bit COND_NV_NEVER = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pc_wr_en,
   input logic              issue_valid,
   input logic [NCLASS-1:0] issue_class,
   input logic [ADDR_W-1:0] issue_addr,
   input logic [3:0]        issue_cond,
   input logic              halted
);
   // R9: exactly one class bit on a valid issue
   a_r9_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid |-> $countones(issue_class) == 1);

   // R9: class vector idle when nothing issues
   a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !issue_valid |-> issue_class == '0);

   // R7: halt is sticky
   a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> halted);

   // R7: nothing issues once halted
   a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> !issue_valid);

   // R8: write edge and refill edge both issue nothing
   a_r8_write_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_wr_en && !halted) |=> (!issue_valid ##1 !issue_valid));

   // R2: back-to-back issues are sequential words
   a_r2_seq: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && $past(issue_valid)) |-> (issue_addr - $past(issue_addr)) == ADDR_W'(4));

   // R6: a never-code word cannot issue
   generate
      if (COND_NV_NEVER) begin : g_nv_chk
         a_r6_never: assert property (@(posedge clk) disable iff (!rst_n)
            issue_valid |-> issue_cond != 4'hF);
      end
   endgenerate
endmodule

bind insn_front insn_front_chk #(.ADDR_W(ADDR_W), .COND_NV_NEVER(COND_NV_NEVER)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .pc_wr_en    (pc_wr_en),
   .issue_valid (issue_valid),
   .issue_class (issue_class),
   .issue_addr  (issue_addr),
   .issue_cond  (issue_word[31:28]),
   .halted      (halted)
);

// File: tb/insn_front_tb.sv
module insn_front_tb;
   localparam int AW = 12;
   localparam logic [AW-1:0] BASE = 12'h040;
   localparam logic [AW-1:0] TGT  = 12'h200;
   localparam logic [31:0]   UNK  = 32'hEC00_0000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] imem_addr;
   logic [31:0]   imem_rdata;
   logic          pc_wr_en = 1'b0;
   logic [AW-1:0] pc_wr_data = '0;
   logic [3:0]    flags_nzcv = 4'h0;
   logic          issue_valid;
   logic [9:0]    issue_class;
   logic [AW-1:0] issue_addr;
   logic [31:0]   issue_word;
   logic          halted;

   logic [31:0] mem [0:255];
   int checks = 0;
   int errors = 0;

   int            lcnt;
   int            cyc;
   logic [AW-1:0] laddr [0:63];
   logic [9:0]    lcls  [0:63];
   int            lcyc  [0:63];

   always #5 clk = ~clk;

   assign imem_rdata = mem[imem_addr[9:2]];

   insn_front #(.ADDR_W(AW), .RESET_PC(BASE), .COND_NV_NEVER(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
      .pc_wr_en(pc_wr_en), .pc_wr_data(pc_wr_data), .flags_nzcv(flags_nzcv),
      .issue_valid(issue_valid), .issue_class(issue_class), .issue_addr(issue_addr),
      .issue_word(issue_word), .halted(halted));

   always @(negedge clk) begin
      if (!rst_n) begin
         lcnt = 0;
         cyc  = 0;
      end else begin
         cyc = cyc + 1;
         if (issue_valid && lcnt < 64) begin
            laddr[lcnt] = issue_addr;
            lcls[lcnt]  = issue_class;
            lcyc[lcnt]  = cyc;
            lcnt = lcnt + 1;
         end
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic bit cond_ok(input logic [3:0] c, input logic [3:0] f);
      bit n, z, cy, v;
      n = f[3]; z = f[2]; cy = f[1]; v = f[0];
      case (c)
         4'h0: return z;
         4'h1: return !z;
         4'h2: return cy;
         4'h3: return !cy;
         4'h4: return n;
         4'h5: return !n;
         4'h6: return v;
         4'h7: return !v;
         4'h8: return cy && !z;
         4'h9: return !cy || z;
         4'hA: return n == v;
         4'hB: return n != v;
         4'hC: return !z && (n == v);
         4'hD: return z || (n != v);
         4'hE: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   task automatic clear_mem();
      for (int i = 0; i < 256; i++) mem[i] = UNK;
   endtask

   task automatic put(input logic [AW-1:0] a, input logic [31:0] w);
      mem[a[9:2]] = w;
   endtask

   task automatic start();
      @(negedge clk);
      rst_n = 1'b0;
      pc_wr_en = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_reset();
      clear_mem();
      for (int i = 0; i < 4; i++) put(BASE + AW'(4*i), 32'hE200_0000);
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 valid in reset", 32'(issue_valid), 0);
      check("R1 halted in reset", 32'(halted), 0);
      check("R1 fetch addr in reset", 32'(imem_addr), 32'(BASE));
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 no issue on refill edge", 32'(issue_valid), 0);
      @(negedge clk);
      check("R1 first issue valid", 32'(issue_valid), 1);
      check("R1 first issue addr", 32'(issue_addr), 32'(BASE));
      @(negedge clk);
      check("R2 second issue addr", 32'(issue_addr), 32'(BASE + 12'd4));
   endtask

   task automatic t_classes();
      logic [31:0] words [0:9];
      logic [AW-1:0] held;
      words[0] = 32'hE000_0090; words[1] = 32'hE100_0000; words[2] = 32'hE120_0000;
      words[3] = 32'hE000_0000; words[4] = 32'hE000_0010; words[5] = 32'hE200_0000;
      words[6] = 32'hE400_0000; words[7] = 32'hE600_0000; words[8] = 32'hE800_0000;
      words[9] = 32'hEA00_0000;
      clear_mem();
      for (int i = 0; i < 10; i++) put(BASE + AW'(4*i), words[i]);
      flags_nzcv = 4'h0;
      start();
      repeat (20) @(negedge clk);
      check("R3 class count", 32'(lcnt), 10);
      for (int i = 0; i < 10; i++) begin
         check("R3 class addr", 32'(laddr[i]), 32'(BASE + AW'(4*i)));
         check("R3 R4 class bit", 32'(lcls[i]), 32'(10'b1 << i));
         if (i > 0) check("R2 consecutive cycles", 32'(lcyc[i] - lcyc[i-1]), 1);
      end
      check("R7 halted after unknown", 32'(halted), 1);
      check("R7 fetch frozen", 32'(imem_addr), 32'(BASE + 12'd48));
      held = imem_addr;
      pc_wr_en = 1'b1; pc_wr_data = TGT;
      @(negedge clk);
      pc_wr_en = 1'b0;
      repeat (6) @(negedge clk);
      check("R7 pc write ignored addr", 32'(imem_addr), 32'(held));
      check("R7 no issue after halt", 32'(lcnt), 10);
      check("R7 still halted", 32'(halted), 1);
      check("R9 idle class", 32'(issue_class), 0);
      // register-offset pattern with bit 4 set is unknown
      clear_mem();
      put(BASE, 32'hE600_0000);
      put(BASE + 12'd4, 32'hE600_0010);
      put(BASE + 12'd8, 32'hE200_0000);
      start();
      repeat (8) @(negedge clk);
      check("R7 bit4 load/store unknown count", 32'(lcnt), 1);
      check("R7 bit4 load/store halts", 32'(halted), 1);
   endtask

   task automatic t_cond(input logic [3:0] f);
      int exp_n;
      clear_mem();
      for (int i = 0; i < 16; i++) put(BASE + AW'(4*i), {4'(i), 28'h200_0000});
      put(BASE + 12'd64, 32'hFC00_0000);
      flags_nzcv = f;
      start();
      repeat (24) @(negedge clk);
      exp_n = 0;
      for (int i = 0; i < 16; i++) begin
         if (cond_ok(4'(i), f)) begin
            if (exp_n < lcnt) begin
               check("R5 passing code addr", 32'(laddr[exp_n]), 32'(BASE + AW'(4*i)));
               check("R5 passing code class", 32'(lcls[exp_n]), 32'(10'b1 << 5));
            end
            exp_n++;
         end
      end
      check("R5 R6 issue count", 32'(lcnt), 32'(exp_n));
      check("R6 halt only at later unknown", 32'(halted), 1);
      check("R6 never-code word skipped", 32'(imem_addr), 32'(BASE + 12'd76));
   endtask

   task automatic t_pcwrite();
      int c1;
      clear_mem();
      for (int i = 0; i < 8; i++) put(BASE + AW'(4*i), 32'hE200_0000);
      for (int i = 0; i < 3; i++) put(TGT + AW'(4*i), 32'hEA00_0000);
      flags_nzcv = 4'h0;
      start();
      repeat (3) @(negedge clk);
      pc_wr_en = 1'b1; pc_wr_data = TGT;
      @(negedge clk);
      pc_wr_en = 1'b0;
      repeat (10) @(negedge clk);
      check("R8 issue count", 32'(lcnt), 5);
      check("R8 pre-write addr", 32'(laddr[1]), 32'(BASE + 12'd4));
      check("R8 target addr", 32'(laddr[2]), 32'(TGT));
      check("R8 target class", 32'(lcls[2]), 32'(10'b1 << 9));
      c1 = lcyc[2] - lcyc[1];
      check("R8 two idle edges", 32'(c1), 3);
      check("R8 after target", 32'(laddr[4]), 32'(TGT + 12'd8));
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      t_reset();
      t_classes();
      t_cond(4'b0110);
      t_cond(4'b1101);
      t_cond(4'b0000);
      t_cond(4'b1010);
      t_pcwrite();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule